// File: doc/BRIEF.md
# SPI Hold-Condition Controller

This block sits between the SPI pins of a serial flash device and its command engine and implements the pause function of the active-low hold pin. It runs on a fast system clock that oversamples the pins. Chip-select, the serial clock and the hold pin pass through two-flop synchronizers before use. A small state machine then decides when the interface is in a session, paused, or waiting out a reset.

A pause starts and ends only while the serial clock is low. A hold edge that arrives while the clock is high waits until the clock next falls. While paused, the block masks the clock-edge strobes that drive the engine's bit counter and shift registers, so those keep their values. It also forces the data-output enable low. If chip-select rises during a pause, the block asserts a logic-reset request. That request stays up until hold is released with chip-select high. A new session then needs a fresh chip-select fall.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, hold_o, logic_rst_o, so_oe_o, sck_rise_o and sck_fall_o are all 0.
- R2: Each of cs_ni, sck_i and hold_ni passes through two synchronizer flops. A pin change driven before clock edge k affects the state outputs (hold_o, logic_rst_o) after edge k+2. It affects the clock strobes after edge k+1.
- R3: hold_o can become 1 only while synchronized cs_ni is 0. A session begins when cs_ni is seen low while the block is idle.
- R4: In a session, hold_ni low together with sck_i low enters the pause (hold_o = 1) on the next state update.
- R5: If hold_ni falls while sck_i is high, hold_o stays 0 until sck_i is seen low.
- R6: The pause ends (hold_o = 0, session resumes) only when hold_ni is high and sck_i is low. A release while sck_i is high is deferred until sck_i is low.
- R7: While hold_o is 1, so_oe_o is 0 whatever so_en_i is.
- R8: While hold_o is 1, sck_rise_o and sck_fall_o stay 0 for any sck_i activity, which freezes the engine's counters.
- R9: cs_ni seen high while hold_o is 1 sets logic_rst_o = 1 and hold_o = 0. logic_rst_o stays 1 until hold_ni and cs_ni are both seen high.
- R10: After a logic reset clears, a session restarts only on cs_ni seen low. No strobes or output enable appear before that.
- R11: cs_ni seen high during a session, outside a pause, ends it without a logic-reset request.
- R12: During a session and outside a pause, so_oe_o follows so_en_i. sck_rise_o and sck_fall_o pulse for one cycle on each synchronized rising and falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| hold_ni | input | 1 | Hold pin, active low |
| so_en_i | input | 1 | Output-enable request from the command engine |
| hold_o | output | 1 | Pause active; engine freezes |
| so_oe_o | output | 1 | Serial-output drive enable (0 = high impedance) |
| sck_rise_o | output | 1 | One-cycle strobe on a synchronized clock rising edge in session |
| sck_fall_o | output | 1 | One-cycle strobe on a synchronized clock falling edge in session |
| logic_rst_o | output | 1 | Request to reset the interface logic |

## Verification
A pin change driven before edge k reaches the synchronized copy after edge k+1. The clock strobes and the combinational output enable respond in the cycle after edge k+1. hold_o and logic_rst_o are registered once more and change after edge k+2. The bench drives and samples on the falling clock edge. A reference model keeps a three-deep history of driven pins and applies each requirement to the pins driven three falling edges earlier. Directed checks count these edges explicitly: for example, a deferred entry is checked as still 0 two edges after sck_i falls and as 1 on the third.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HOLD   = 2'd2,
    ST_LOCK   = 2'd3
  } hold_st_e;

  localparam int unsigned PIN_N   = 3;
  localparam int unsigned PIN_CS  = 0;
  localparam int unsigned PIN_SCK = 1;
  localparam int unsigned PIN_HLD = 2;
  // idle pin levels: cs high, sck low, hold high
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b101;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_sck_edge.sv
module spi_sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end
  assign rise_o = sck_s_i & ~sck_q;
  assign fall_o = ~sck_s_i & sck_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_s_i,
  input  logic     sck_s_i,
  input  logic     hold_s_i,
  output hold_st_e st_o
);
  hold_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (!cs_s_i) st_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (cs_s_i)                      st_d = ST_IDLE;
        else if (!hold_s_i && !sck_s_i) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (cs_s_i)                     st_d = ST_LOCK;
        else if (hold_s_i && !sck_s_i) st_d = ST_ACTIVE;
      end
      ST_LOCK:   if (cs_s_i && hold_s_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  p_hold_needs_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> $past(!cs_s_i));
  p_enter_sck_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && $past(st_q) == ST_ACTIVE) |-> $past(!sck_s_i && !hold_s_i));
  p_exit_sck_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACTIVE && $past(st_q) == ST_HOLD) |-> $past(!sck_s_i && hold_s_i));
  p_cs_in_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_HOLD && $past(cs_s_i)) |-> (st_q == ST_LOCK));
  p_lock_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_LOCK && st_q != ST_LOCK) |-> $past(cs_s_i && hold_s_i));
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic so_en_i,
  output logic hold_o,
  output logic so_oe_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic logic_rst_o
);
  logic [PIN_N-1:0] pins_raw, pins_s;
  logic             rise, fall;
  hold_st_e         st;

  assign pins_raw[PIN_CS]  = cs_ni;
  assign pins_raw[PIN_SCK] = sck_i;
  assign pins_raw[PIN_HLD] = hold_ni;

  spi_pin_sync #(
    .WIDTH   (PIN_N),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  spi_sck_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_s_i (pins_s[PIN_SCK]),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  spi_hold_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_i   (pins_s[PIN_CS]),
    .sck_s_i  (pins_s[PIN_SCK]),
    .hold_s_i (pins_s[PIN_HLD]),
    .st_o     (st)
  );

  logic in_session;
  assign in_session  = (st == ST_ACTIVE);
  assign hold_o      = (st == ST_HOLD);
  assign logic_rst_o = (st == ST_LOCK);
  assign so_oe_o     = so_en_i & in_session;
  assign sck_rise_o  = rise & in_session;
  assign sck_fall_o  = fall & in_session;

  p_oe_off_in_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !so_oe_o);
  p_no_strobe_in_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !(sck_rise_o || sck_fall_o));
  p_one_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hold_o, logic_rst_o, so_oe_o}));
endmodule

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, so_en = 1'b0;
  logic hold_w, oe_w, rise_w, fall_w, lrst_w;
  int   checks = 0, errors = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .hold_ni(hold_n),
    .so_en_i(so_en), .hold_o(hold_w), .so_oe_o(oe_w), .sck_rise_o(rise_w),
    .sck_fall_o(fall_w), .logic_rst_o(lrst_w)
  );

  // model: 0 idle, 1 session, 2 paused, 3 reset wait
  int   m_st = 0;
  logic h_cs[3], h_sck[3], h_hld[3];

  function automatic int next_st(int s, logic c, logic k, logic h);
    case (s)
      0: return c ? 0 : 1;
      1: return c ? 0 : ((!h && !k) ? 2 : 1);
      2: return c ? 3 : ((h && !k) ? 1 : 2);
      default: return (c && h) ? 0 : 3;
    endcase
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one falling edge: update model, compare outputs, then drive new pins
  task automatic tick(logic c, logic k, logic h, logic e);
    logic r_exp, f_exp;
    @(negedge clk);
    m_st  = next_st(m_st, h_cs[2], h_sck[2], h_hld[2]);
    r_exp = (m_st == 1) &&  h_sck[1] && !h_sck[2];
    f_exp = (m_st == 1) && !h_sck[1] &&  h_sck[2];
    chk("R4/R5/R6", "hold_o", hold_w, m_st == 2);
    chk("R9/R10", "logic_rst_o", lrst_w, m_st == 3);
    chk(m_st == 2 ? "R7" : "R12", "so_oe_o", oe_w, so_en && m_st == 1);
    chk(m_st == 2 ? "R8" : "R12", "sck_rise_o", rise_w, r_exp);
    chk(m_st == 2 ? "R8" : "R12", "sck_fall_o", fall_w, f_exp);
    cs_n = c; sck = k; hold_n = h; so_en = e;
    h_cs[2] = h_cs[1];   h_cs[1] = h_cs[0];   h_cs[0] = c;
    h_sck[2] = h_sck[1]; h_sck[1] = h_sck[0]; h_sck[0] = k;
    h_hld[2] = h_hld[1]; h_hld[1] = h_hld[0]; h_hld[0] = h;
  endtask

  task automatic hold_pins(logic c, logic k, logic h, logic e, int n);
    for (int i = 0; i < n; i++) tick(c, k, h, e);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > WATCHDOG && !done) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", wd, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic c, k, h, e;
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin
      h_cs[i] = 1'b1; h_sck[i] = 1'b0; h_hld[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "hold_o", hold_w, 1'b0);
    chk("R1", "logic_rst_o", lrst_w, 1'b0);
    chk("R1", "so_oe_o", oe_w, 1'b0);
    chk("R1", "strobes", rise_w | fall_w, 1'b0);
    rst_n = 1'b1;

    // R3: session opens, then R5 deferred entry with sck high
    hold_pins(1'b0, 1'b1, 1'b1, 1'b1, 6);
    chk("R12", "so_oe_o in session", oe_w, 1'b1);
    hold_pins(1'b0, 1'b1, 1'b0, 1'b1, 6);
    chk("R5", "hold_o deferred while sck high", hold_w, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R2", "hold_o two edges after sck fall", hold_w, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5", "hold_o after sck low", hold_w, 1'b1);
    chk("R7", "so_oe_o forced off", oe_w, 1'b0);
    // R8: toggling sck during pause gives no strobe
    for (int i = 0; i < 8; i++) begin
      tick(1'b0, i[0], 1'b0, 1'b1);
      chk("R8", "strobe during pause", rise_w | fall_w, 1'b0);
    end
    // R6: release while sck high is deferred
    hold_pins(1'b0, 1'b1, 1'b1, 1'b1, 6);
    chk("R6", "hold_o kept while sck high", hold_w, 1'b1);
    hold_pins(1'b0, 1'b0, 1'b1, 1'b1, 4);
    chk("R6", "hold_o released at sck low", hold_w, 1'b0);
    // R4: immediate entry with sck low
    hold_pins(1'b0, 1'b0, 1'b0, 1'b0, 4);
    chk("R4", "hold_o with sck low", hold_w, 1'b1);
    // R9: cs high during pause
    hold_pins(1'b1, 1'b0, 1'b0, 1'b0, 4);
    chk("R9", "logic_rst_o", lrst_w, 1'b1);
    chk("R9", "hold_o cleared", hold_w, 1'b0);
    hold_pins(1'b0, 1'b0, 1'b1, 1'b1, 6);
    chk("R10", "reset held with cs low", lrst_w, 1'b1);
    chk("R10", "no oe before fresh cs", oe_w, 1'b0);
    hold_pins(1'b1, 1'b0, 1'b1, 1'b1, 4);
    chk("R9", "logic_rst_o released", lrst_w, 1'b0);
    hold_pins(1'b0, 1'b0, 1'b1, 1'b1, 4);
    chk("R10", "session after fresh cs", oe_w, 1'b1);
    // R11: cs high outside pause
    hold_pins(1'b1, 1'b0, 1'b1, 1'b1, 4);
    chk("R11", "no reset request", lrst_w, 1'b0);
    chk("R11", "session ended", oe_w, 1'b0);
    // R3: hold low with cs high never pauses
    hold_pins(1'b1, 1'b0, 1'b0, 1'b1, 6);
    chk("R3", "no pause without cs", hold_w, 1'b0);

    // random phase
    c = 1'b0; k = 1'b0; h = 1'b1; e = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 2) == 0)  k = ~k;
      if ($urandom_range(0, 9) == 0)  h = ~h;
      if ($urandom_range(0, 59) == 0) c = ~c;
      e = ($urandom_range(0, 3) != 0);
      tick(c, k, h, e);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule